// File: doc/BRIEF.md
# Shared-Period Eight-Channel PWM Timer

This block produces eight pulse-width-modulated outputs from one 16-bit up-counter. The counter advances on ticks from one of three external tick-enable sources, which pass through a power-of-two prescaler. All channels share the counter, its start value and its modulo, so they all have the same period. Each channel compares the counter with its own compare value to make an edge-aligned waveform. Each channel can also be inverted, or masked so that it sits at its idle level.

Software reaches the block over a simple word-wide register bus. A write takes effect on the clock edge where the write strobe is high, and read data is combinational from the address. The live counter can be read at any time. Modulo and compare values are double-buffered: a value that is written waits for the next counter wrap, so a period already running is never cut short. The block runs in the one clock domain of the bus, and the tick sources are single-cycle enables in that domain.

Top module: `pwm_timer8`

## Requirements
- R1: After a synchronous reset every register reads zero, except the output-mask register at 0x60, which reads 0xFF. All eight outputs are then low.
- R2: The counter holds its value when the source field (bits 4:3 of the control register at 0x00) is 0. Values 1, 2 and 3 make tick_in bit 0, 1 or 2, respectively, the tick source.
- R3: The prescale field (bits 2:0 at 0x00) makes the counter advance once every 2^PS selected ticks.
- R4: On an advance with the counter equal to the active modulo, the counter reloads the start value at 0x4C. On any other advance it increments by one, so a period lasts modulo+1 advances.
- R5: Offset 0x04 reads the live counter value, and writes to 0x04 have no effect.
- R6: Channel n has a control register at 0x0C+8n and a compare register at 0x10+8n, for n from 0 to 7. Both read back what was last written to them: 8 bits of control, 16 bits of compare.
- R7: A channel whose control register has bits 5 and 3 both set is in PWM mode. Its un-inverted level is high while the counter is below its active compare value and low otherwise.
- R8: In PWM mode, a compare value of 0 keeps the un-inverted level low. A compare value above the modulo keeps it high.
- R9: Bit n of the polarity register at 0x70 inverts output n.
- R10: Bit n of the mask register at 0x60 forces output n to its inactive level, which equals polarity bit n.
- R11: A channel that is not in PWM mode and not masked drives bit n of the init register at 0x5C, XORed with polarity bit n.
- R12: Written modulo and compare values become active only at the next counter wrap. A write made in the same cycle as a wrap waits for the wrap after it.
- R13: Reads of unimplemented offsets return zero, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| tick_in | input | 3 | Tick enables for counter sources 1 to 3 |
| pwm_out | output | 8 | Channel outputs |

## Verification
Two events can fall in the same cycle: a counter wrap, which copies the buffered modulo and compare values into the active set, and a bus write to those same buffered registers. The bench provokes this by running the prescaler at divide-by-one with ticks held on. It waits until its model shows the counter equal to the active modulo, then issues a modulo write in exactly that cycle. It checks the outcome by reading the counter back: the period that follows must still use the previous modulo, and the new one must govern only the period after that. A prescaler change that lands while a count is in progress is judged the same way, by comparing against the model cycle by cycle.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

    localparam int DW   = 32;
    localparam int AW   = 8;
    localparam int PSW  = 3;
    localparam int SRCW = 2;
    localparam int NSRC = 3;
    localparam int CHW  = 8;

    localparam int OFS_CTL    = 'h00;
    localparam int OFS_COUNT  = 'h04;
    localparam int OFS_MODULO = 'h08;
    localparam int OFS_CH0    = 'h0C;
    localparam int CH_STRIDE  = 8;
    localparam int OFS_START  = 'h4C;
    localparam int OFS_INIT   = 'h5C;
    localparam int OFS_MASK   = 'h60;
    localparam int OFS_INVERT = 'h70;

    localparam int MODE_BIT_HI = 5;
    localparam int MODE_BIT_LO = 3;

    typedef enum logic [SRCW-1:0] {
        SRC_OFF = 2'd0,
        SRC_A   = 2'd1,
        SRC_B   = 2'd2,
        SRC_C   = 2'd3
    } src_e;

    typedef struct packed {
        logic [SRCW-1:0] src;
        logic [PSW-1:0]  ps;
    } tmr_ctl_t;

    function automatic int ch_ctl_ofs(int n);
        return OFS_CH0 + CH_STRIDE * n;
    endfunction

    function automatic int ch_cmp_ofs(int n);
        return OFS_CH0 + 4 + CH_STRIDE * n;
    endfunction

    function automatic logic is_edge_pwm(logic [CHW-1:0] c);
        return c[MODE_BIT_HI] & c[MODE_BIT_LO];
    endfunction

endpackage

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen
    import pwm_timer_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [SRCW-1:0] src_sel,
    input  logic [PSW-1:0]  ps,
    input  logic [NSRC-1:0] tick_in,
    output logic            adv
);
    localparam int PREW = (1 << PSW) - 1;

    logic            tick;
    logic [PREW-1:0] pre_q;
    logic [PREW-1:0] pre_lim;

    always_comb begin
        case (src_e'(src_sel))
            SRC_A:   tick = tick_in[0];
            SRC_B:   tick = tick_in[1];
            SRC_C:   tick = tick_in[2];
            default: tick = 1'b0;
        endcase
    end

    assign pre_lim = (PREW'(1) << ps) - PREW'(1);
    assign adv     = tick && (pre_q >= pre_lim);

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q <= '0;
        end else if (tick) begin
            pre_q <= adv ? '0 : pre_q + PREW'(1);
        end
    end

endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv,
    input  logic [CW-1:0] mod_act,
    input  logic [CW-1:0] cntin,
    output logic [CW-1:0] cnt,
    output logic          wrap
);
    logic [CW-1:0] cnt_q;

    assign cnt  = cnt_q;
    assign wrap = adv && (cnt_q == mod_act);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (adv) begin
            cnt_q <= wrap ? cntin : cnt_q + CW'(1);
        end
    end

endmodule

// File: rtl/pwm_regfile.sv
module pwm_regfile
    import pwm_timer_pkg::*;
#(
    parameter int NCH = 8,
    parameter int CW  = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     bus_we,
    input  logic [AW-1:0]            bus_addr,
    input  logic [DW-1:0]            bus_wdata,
    output logic [DW-1:0]            bus_rdata,
    input  logic [CW-1:0]            cnt,
    input  logic                     wrap,
    output logic [SRCW-1:0]          src_sel,
    output logic [PSW-1:0]           ps,
    output logic [CW-1:0]            mod_act,
    output logic [CW-1:0]            cntin,
    output logic [NCH-1:0][CHW-1:0]  ch_ctl,
    output logic [NCH-1:0][CW-1:0]   cv_act,
    output logic [NCH-1:0]           oinit,
    output logic [NCH-1:0]           mask,
    output logic [NCH-1:0]           pol
);
    localparam int CTLW = SRCW + PSW;

    tmr_ctl_t               ctl_q;
    logic [CW-1:0]          mod_q;
    logic [CW-1:0]          mod_a;
    logic [CW-1:0]          cntin_q;
    logic [NCH-1:0]         oinit_q;
    logic [NCH-1:0]         mask_q;
    logic [NCH-1:0]         pol_q;
    logic [NCH-1:0][CW-1:0] cv_reg;
    logic [NCH-1:0]         ctl_hit;
    logic [NCH-1:0]         cmp_hit;
    logic                   unused_wdata;

    assign unused_wdata = ^bus_wdata[DW-1:CW];

    assign src_sel = ctl_q.src;
    assign ps      = ctl_q.ps;
    assign mod_act = mod_a;
    assign cntin   = cntin_q;
    assign oinit   = oinit_q;
    assign mask    = mask_q;
    assign pol     = pol_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q   <= '0;
            mod_q   <= '0;
            mod_a   <= '0;
            cntin_q <= '0;
            oinit_q <= '0;
            mask_q  <= '1;
            pol_q   <= '0;
        end else begin
            if (bus_we && bus_addr == AW'(OFS_CTL))    ctl_q   <= tmr_ctl_t'(bus_wdata[CTLW-1:0]);
            if (bus_we && bus_addr == AW'(OFS_MODULO)) mod_q   <= bus_wdata[CW-1:0];
            if (bus_we && bus_addr == AW'(OFS_START))  cntin_q <= bus_wdata[CW-1:0];
            if (bus_we && bus_addr == AW'(OFS_INIT))   oinit_q <= bus_wdata[NCH-1:0];
            if (bus_we && bus_addr == AW'(OFS_MASK))   mask_q  <= bus_wdata[NCH-1:0];
            if (bus_we && bus_addr == AW'(OFS_INVERT)) pol_q   <= bus_wdata[NCH-1:0];
            if (wrap)                                  mod_a   <= mod_q;
        end
    end

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        localparam logic [AW-1:0] A_CTL = AW'(ch_ctl_ofs(n));
        localparam logic [AW-1:0] A_CMP = AW'(ch_cmp_ofs(n));

        logic [CHW-1:0] ctl_r;
        logic [CW-1:0]  cmp_r;
        logic [CW-1:0]  cmp_a;

        assign ctl_hit[n] = (bus_addr == A_CTL);
        assign cmp_hit[n] = (bus_addr == A_CMP);
        assign ch_ctl[n]  = ctl_r;
        assign cv_reg[n]  = cmp_r;
        assign cv_act[n]  = cmp_a;

        always_ff @(posedge clk) begin
            if (rst) begin
                ctl_r <= '0;
                cmp_r <= '0;
                cmp_a <= '0;
            end else begin
                if (bus_we && ctl_hit[n]) ctl_r <= bus_wdata[CHW-1:0];
                if (bus_we && cmp_hit[n]) cmp_r <= bus_wdata[CW-1:0];
                if (wrap)                 cmp_a <= cmp_r;
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            AW'(OFS_CTL):    bus_rdata = DW'(ctl_q);
            AW'(OFS_COUNT):  bus_rdata = DW'(cnt);
            AW'(OFS_MODULO): bus_rdata = DW'(mod_q);
            AW'(OFS_START):  bus_rdata = DW'(cntin_q);
            AW'(OFS_INIT):   bus_rdata = DW'(oinit_q);
            AW'(OFS_MASK):   bus_rdata = DW'(mask_q);
            AW'(OFS_INVERT): bus_rdata = DW'(pol_q);
            default:         bus_rdata = '0;
        endcase
        for (int n = 0; n < NCH; n++) begin
            if (ctl_hit[n]) bus_rdata = DW'(ch_ctl[n]);
            if (cmp_hit[n]) bus_rdata = DW'(cv_reg[n]);
        end
    end

endmodule

// File: rtl/pwm_chan_out.sv
module pwm_chan_out
    import pwm_timer_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic [CW-1:0]  cnt,
    input  logic [CW-1:0]  cmp,
    input  logic [CHW-1:0] ctl,
    input  logic           mask_b,
    input  logic           pol_b,
    input  logic           init_b,
    output logic           pwm
);
    logic level;
    logic unused_ctl;

    assign unused_ctl = ^{ctl[CHW-1:MODE_BIT_HI+1], ctl[MODE_BIT_HI-1:MODE_BIT_LO+1],
                          ctl[MODE_BIT_LO-1:0]};

    always_comb begin
        if (mask_b)               level = 1'b0;
        else if (is_edge_pwm(ctl)) level = (cnt < cmp);
        else                       level = init_b;
        pwm = level ^ pol_b;
    end

endmodule

// File: rtl/pwm_timer8.sv
module pwm_timer8
    import pwm_timer_pkg::*;
#(
    parameter int NCH = 8,
    parameter int CW  = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            bus_we,
    input  logic [AW-1:0]   bus_addr,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    input  logic [NSRC-1:0] tick_in,
    output logic [NCH-1:0]  pwm_out
);
    logic [SRCW-1:0]         src_sel;
    logic [PSW-1:0]          ps;
    logic [CW-1:0]           mod_act;
    logic [CW-1:0]           cntin;
    logic [CW-1:0]           cnt;
    logic                    adv;
    logic                    wrap;
    logic [NCH-1:0][CHW-1:0] ch_ctl;
    logic [NCH-1:0][CW-1:0]  cv_act;
    logic [NCH-1:0]          oinit;
    logic [NCH-1:0]          mask;
    logic [NCH-1:0]          pol;

    pwm_regfile #(.NCH(NCH), .CW(CW)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cnt       (cnt),
        .wrap      (wrap),
        .src_sel   (src_sel),
        .ps        (ps),
        .mod_act   (mod_act),
        .cntin     (cntin),
        .ch_ctl    (ch_ctl),
        .cv_act    (cv_act),
        .oinit     (oinit),
        .mask      (mask),
        .pol       (pol)
    );

    pwm_tick_gen u_tick (
        .clk     (clk),
        .rst     (rst),
        .src_sel (src_sel),
        .ps      (ps),
        .tick_in (tick_in),
        .adv     (adv)
    );

    pwm_counter #(.CW(CW)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .adv     (adv),
        .mod_act (mod_act),
        .cntin   (cntin),
        .cnt     (cnt),
        .wrap    (wrap)
    );

    for (genvar n = 0; n < NCH; n++) begin : g_out
        pwm_chan_out #(.CW(CW)) u_ch (
            .cnt    (cnt),
            .cmp    (cv_act[n]),
            .ctl    (ch_ctl[n]),
            .mask_b (mask[n]),
            .pol_b  (pol[n]),
            .init_b (oinit[n]),
            .pwm    (pwm_out[n])
        );
    end

endmodule

// File: rtl/pwm_timer8_chk.sv
module pwm_timer8_chk
    import pwm_timer_pkg::*;
#(
    parameter int NCH = 8,
    parameter int CW  = 16
) (
    input logic            clk,
    input logic            rst,
    input logic [CW-1:0]   cnt,
    input logic [CW-1:0]   cntin,
    input logic [CW-1:0]   mod_act,
    input logic            adv,
    input logic            wrap,
    input logic [SRCW-1:0] src_sel,
    input logic [NCH-1:0]  mask,
    input logic [NCH-1:0]  pol,
    input logic [NCH-1:0]  pwm_out
);

    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (mask == '1 && pwm_out == '0));

    a_r2_stopped_holds: assert property (@(posedge clk) disable iff (rst)
        (src_sel == '0) |=> $stable(cnt));

    a_r3_adv_needs_source: assert property (@(posedge clk) disable iff (rst)
        adv |-> (src_sel != '0));

    a_r4_reload_start: assert property (@(posedge clk) disable iff (rst)
        wrap |=> (cnt == $past(cntin)));

    a_r4_step_one: assert property (@(posedge clk) disable iff (rst)
        (adv && !wrap) |=> (cnt == $past(cnt) + CW'(1)));

    a_r10_mask_idle: assert property (@(posedge clk) disable iff (rst)
        ((pwm_out & mask) == (pol & mask)));

    a_r12_modulo_held: assert property (@(posedge clk) disable iff (rst)
        !wrap |=> $stable(mod_act));

endmodule

bind pwm_timer8 pwm_timer8_chk #(.NCH(NCH), .CW(CW)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .cnt     (cnt),
    .cntin   (cntin),
    .mod_act (mod_act),
    .adv     (adv),
    .wrap    (wrap),
    .src_sel (src_sel),
    .mask    (mask),
    .pol     (pol),
    .pwm_out (pwm_out)
);

// File: tb/pwm_timer8_tb.sv
module pwm_timer8_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        we = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [2:0]  tick = '0;
    logic [7:0]  pout;

    int checks = 0;
    int errs = 0;
    bit done = 0;

    int m_src, m_ps, m_pre, m_cnt, m_mod, m_moda, m_cntin, m_init, m_mask, m_pol;
    int m_ctl[NCH];
    int m_cv[NCH];
    int m_cva[NCH];

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_timer8 u_dut (
        .clk(clk), .rst(rst), .bus_we(we), .bus_addr(addr), .bus_wdata(wdata),
        .bus_rdata(rdata), .tick_in(tick), .pwm_out(pout)
    );

    // Behavioural reference model, stepped on every rising edge.
    always @(posedge clk) begin
        if (rst) begin
            m_src = 0; m_ps = 0; m_pre = 0; m_cnt = 0; m_mod = 0; m_moda = 0;
            m_cntin = 0; m_init = 0; m_mask = 255; m_pol = 0;
            for (int n = 0; n < NCH; n++) begin m_ctl[n] = 0; m_cv[n] = 0; m_cva[n] = 0; end
        end else begin
            bit t;
            bit a;
            t = (m_src != 0) && tick[m_src-1];
            a = 0;
            if (t) begin
                if (m_pre >= (1 << m_ps) - 1) begin m_pre = 0; a = 1; end
                else m_pre = m_pre + 1;
            end
            if (a) begin
                if (m_cnt == m_moda) begin
                    m_cnt = m_cntin;
                    m_moda = m_mod;
                    for (int n = 0; n < NCH; n++) m_cva[n] = m_cv[n];
                end else m_cnt = (m_cnt + 1) % 65536;
            end
            if (we) begin
                case (addr)
                    8'h00: begin m_src = int'(wdata[4:3]); m_ps = int'(wdata[2:0]); end
                    8'h08: m_mod = int'(wdata[15:0]);
                    8'h4C: m_cntin = int'(wdata[15:0]);
                    8'h5C: m_init = int'(wdata[7:0]);
                    8'h60: m_mask = int'(wdata[7:0]);
                    8'h70: m_pol = int'(wdata[7:0]);
                    default: begin
                        for (int n = 0; n < NCH; n++) begin
                            if (int'(addr) == 12 + 8*n) m_ctl[n] = int'(wdata[7:0]);
                            if (int'(addr) == 16 + 8*n) m_cv[n] = int'(wdata[15:0]);
                        end
                    end
                endcase
            end
        end
    end

    function automatic logic [31:0] exp_rd(logic [7:0] a);
        logic [31:0] r;
        r = 0;
        case (a)
            8'h00: r = 32'((m_src << 3) | m_ps);
            8'h04: r = 32'(m_cnt);
            8'h08: r = 32'(m_mod);
            8'h4C: r = 32'(m_cntin);
            8'h5C: r = 32'(m_init);
            8'h60: r = 32'(m_mask);
            8'h70: r = 32'(m_pol);
            default: begin
                for (int n = 0; n < NCH; n++) begin
                    if (int'(a) == 12 + 8*n) r = 32'(m_ctl[n]);
                    if (int'(a) == 16 + 8*n) r = 32'(m_cv[n]);
                end
            end
        endcase
        return r;
    endfunction

    function automatic logic [7:0] exp_out();
        logic [7:0] o;
        for (int n = 0; n < NCH; n++) begin
            bit lv;
            if ((m_mask >> n) & 1) lv = 0;
            else if ((m_ctl[n] & 8'h28) == 8'h28) lv = (m_cnt < m_cva[n]);
            else lv = bit'((m_init >> n) & 1);
            o[n] = lv ^ bit'((m_pol >> n) & 1);
        end
        return o;
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errs++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Caller is just after a falling edge.
    task automatic rd_chk(input logic [7:0] a, input string tag);
        addr = a;
        #1;
        check(tag, rdata, exp_rd(a));
    endtask

    task automatic rd_const(input logic [7:0] a, input logic [31:0] exp, input string tag);
        addr = a;
        #1;
        check(tag, rdata, exp);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        we = 1; addr = a; wdata = d;
        @(negedge clk);
        we = 0;
    endtask

    task automatic cyc(input int k);
        repeat (k) @(negedge clk);
    endtask

    // Output compared against the model on every cycle (R7 R8 R9 R10 R11).
    always @(negedge clk) begin
        if (!rst && !done) check("R7/R8/R9/R10/R11 outputs", 32'(pout), 32'(exp_out()));
    end

    initial begin
        cyc(3);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        rd_const(8'h00, 32'h0, "R1 control reset");
        rd_const(8'h60, 32'hFF, "R1 mask reset");
        rd_const(8'h08, 32'h0, "R1 modulo reset");
        check("R1 outputs low", 32'(pout), 32'h0);
        // R13 unimplemented offsets
        rd_const(8'h54, 32'h0, "R13 unimplemented read");
        wr(8'h54, 32'hFFFF_FFFF);
        rd_const(8'h54, 32'h0, "R13 write ignored");
        rd_const(8'h80, 32'h0, "R13 unimplemented read high");

        // R6 channel layout and setup
        wr(8'h08, 9);
        wr(8'h0C, 32'h28); wr(8'h10, 4);
        wr(8'h14, 32'h28); wr(8'h18, 0);
        wr(8'h1C, 32'h28); wr(8'h20, 12);
        wr(8'h24, 32'h28); wr(8'h28, 7);
        wr(8'h2C, 32'h28); wr(8'h30, 5);
        wr(8'h34, 32'h00); wr(8'h38, 3);
        wr(8'h3C, 32'h20); wr(8'h40, 2);
        wr(8'h44, 32'h2B); wr(8'h48, 32'h1_0009);
        rd_const(8'h24, 32'h28, "R6 ch3 control readback");
        rd_const(8'h28, 32'h7, "R6 ch3 compare readback");
        rd_const(8'h44, 32'h2B, "R6 ch7 control readback");
        rd_const(8'h48, 32'h9, "R6 ch7 compare readback");
        wr(8'h70, 32'h48);
        wr(8'h5C, 32'h20);
        wr(8'h60, 32'h10);

        // R2 source select
        tick = 3'b111;
        cyc(5);
        rd_const(8'h04, 32'h0, "R2 stopped with source 0");
        wr(8'h00, 32'h10);
        tick = 3'b001;
        cyc(5);
        rd_const(8'h04, 32'h0, "R2 other source ignored");
        tick = 3'b010;
        cyc(5);
        rd_const(8'h04, 32'h4, "R2 selected source counts");

        // R4 and R7/R8 free run at divide-by-one
        wr(8'h00, 32'h08);
        tick = 3'b111;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (i % 7 == 0) rd_chk(8'h04, "R4 counter vs model");
            if (i == 11) begin
                check("R8 compare zero stays low", 32'(pout[1]), 32'h0);
                check("R8 compare above modulo stays high", 32'(pout[2]), 32'h1);
                check("R7 edge level", 32'(pout[0]), 32'(m_cnt < 4));
            end
        end

        // R3 prescaler 2^2
        wr(8'h00, 32'h0A);
        for (int i = 0; i < 24; i++) begin
            @(negedge clk);
            if (i % 5 == 0) rd_chk(8'h04, "R3 prescaled counter");
        end
        tick = 3'b101;
        cyc(13);
        rd_chk(8'h04, "R3 gapped ticks");
        tick = 3'b111;

        // R5 live read, write ignored
        wr(8'h04, 32'h1234);
        rd_chk(8'h04, "R5 count write ignored");
        cyc(3);
        rd_chk(8'h04, "R5 live count");

        // R12 buffered modulo and same-cycle write
        wr(8'h00, 32'h08);
        wr(8'h08, 5);
        wr(8'h10, 8);
        while (!(m_cnt == m_moda && m_moda == 5)) @(negedge clk);
        we = 1; addr = 8'h08; wdata = 3;
        @(negedge clk);
        we = 0;
        rd_const(8'h04, 32'h0, "R12 wrap after same-cycle write");
        cyc(5);
        rd_const(8'h04, 32'h5, "R12 old modulo still in force");
        cyc(1);
        rd_const(8'h04, 32'h0, "R12 wrap at old modulo");
        cyc(3);
        rd_const(8'h04, 32'h3, "R12 new modulo reached");
        cyc(1);
        rd_const(8'h04, 32'h0, "R12 wrap at new modulo");

        // R4 start value reload
        wr(8'h4C, 2);
        while (m_cnt != m_moda) @(negedge clk);
        @(negedge clk);
        rd_const(8'h04, 32'h2, "R4 reload start value");
        cyc(1);
        rd_const(8'h04, 32'h3, "R4 step after reload");

        // R9 and R10 polarity and mask
        wr(8'h70, 32'hA5);
        cyc(4);
        wr(8'h60, 32'hFF);
        check("R10 all masked idle at polarity", 32'(pout), 32'hA5);
        wr(8'h70, 32'h00);
        check("R10 all masked low", 32'(pout), 32'h00);
        // R11 non-PWM channel follows init XOR polarity
        wr(8'h60, 32'h00);
        wr(8'h5C, 32'h60);
        check("R11 ch5 init high", 32'(pout[5]), 32'h1);
        wr(8'h70, 32'h60);
        check("R11 ch5 init inverted", 32'(pout[5]), 32'h0);
        check("R9 ch6 inverted init", 32'(pout[6]), 32'h0);
        cyc(20);

        // R1 reset again
        rst = 1;
        cyc(2);
        rst = 0;
        @(negedge clk);
        rd_const(8'h60, 32'hFF, "R1 mask after second reset");
        rd_const(8'h04, 32'h0, "R1 counter after second reset");
        check("R1 outputs after second reset", 32'(pout), 32'h0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errs++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

endmodule